// File: doc/BRIEF.md
# Single-Wire Bus Identifier Search Engine

This block runs one pass of the binary-tree walk that discovers the 64-bit identifiers of the devices sharing a single-wire bus. It drives a separate bit-level master through a simple request/done handshake. The master can issue a bus reset with presence sampling, one write slot, or one read slot. For each pass the caller supplies the identifier pattern and the last-discrepancy index returned by the previous pass. For the very first pass it supplies an all-zero pattern and index 0.

A pass starts with a bus reset. If a device answers, the block sends the eight-slot search command. It then resolves the identifier positions one at a time: two read slots return the wired-AND of every still-active device's bit and of its complement, and one write slot sends back the chosen branch. At the end the block returns the identifier it followed, the new discrepancy index and a result code. The caller repeats passes, feeding each result back in, until the code reports that the last device has been found.

Top module: `idsearch_engine`

## Requirements
- R1: After reset, `busy`, `done` and `bm_req` are low, and no bit-level request is issued while the block is idle.
- R2: A pass begins with exactly one reset request (`bm_op`=0). If `bm_rbit` returns 0 (no presence), the pass ends with `result`=2 and issues no further request.
- R3: After presence, the command byte F0h is sent as eight write requests (`bm_op`=1), least significant bit first, with `bm_wbit` carrying each bit.
- R4: Each identifier position uses two read requests (`bm_op`=2) followed by one write. If both reads return 1, the pass ends at once with `result`=3 and without the write.
- R5: When the two reads differ, the chosen bit equals the first read value.
- R6: When both reads are 0, the chosen bit is 1 if the position equals the previous discrepancy, 0 if the position is greater, and otherwise the bit of the previous pattern at that position.
- R7: The returned discrepancy is the last position where both reads were 0 and 0 was chosen, or 0 if there is no such position. `result` is 1 when the discrepancy is 0 and 0 otherwise. Repeated passes enumerate every device exactly once.
- R8: Identifier position k (1..64) is written back and reported in `found_id[k-1]`. `done` is a one-cycle pulse with the results valid. `busy` is high from the cycle after an accepted start until `done`.
- R9: A start pulse, or a change to `prev_id`/`prev_disc`, while a pass is in progress has no effect on that pass.
- R10: At most one bit-level request is outstanding: after `bm_req`, no new request is made until `bm_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that launches one search pass when idle |
| prev_id | input | ID_BITS | Pattern returned by the previous pass (zero for the first) |
| prev_disc | input | IDXW | Discrepancy returned by the previous pass (zero for the first) |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse: results valid |
| found_id | output | ID_BITS | Identifier followed on this pass, position 1 in bit 0 |
| found_disc | output | IDXW | New last-discrepancy index |
| result | output | 2 | 0 more devices, 1 last device, 2 no presence, 3 failed |
| bm_req | output | 1 | One-cycle request to the bit-level master |
| bm_op | output | 2 | 0 reset, 1 write slot, 2 read slot |
| bm_wbit | output | 1 | Bit for a write slot |
| bm_done | input | 1 | Bit-level operation finished |
| bm_rbit | input | 1 | Read value, or presence (1) after a reset |

## Verification
Several actions fall in the same cycle. When the second read of a position completes, the block must detect a clash, pick the branch, record a discrepancy and overwrite the pattern bit. It has to do this while still reading the old bit of that same pattern position. A modelled device population with shared prefixes forces zero-zero forks at positions below, at and above the supplied discrepancy, and a stuck-high bus forces the clash. A second case is a start that arrives during a pass. It is provoked mid-pass together with altered previous inputs. Both cases are judged against a bench reference of the search rule, against the expected request counts, and by requiring that full enumeration finds every device exactly once.

// File: rtl/idsearch_pkg.sv
package idsearch_pkg;

    typedef enum logic [1:0] {
        BM_RESET = 2'd0,
        BM_WRITE = 2'd1,
        BM_READ  = 2'd2
    } bm_op_e;

    typedef enum logic [1:0] {
        RES_MORE  = 2'd0,
        RES_LAST  = 2'd1,
        RES_NODEV = 2'd2,
        RES_FAIL  = 2'd3
    } res_code_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_REQ,
        ST_RST_WAIT,
        ST_CMD_REQ,
        ST_CMD_WAIT,
        ST_RDA_REQ,
        ST_RDA_WAIT,
        ST_RDB_REQ,
        ST_RDB_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_DONE
    } srch_state_e;

    // outcome of the branch decision for one identifier position
    typedef struct packed {
        logic choice;
        logic fork_zero;
        logic clash;
    } branch_t;

    function automatic logic is_request(input srch_state_e s);
        return (s == ST_RST_REQ) || (s == ST_CMD_REQ) || (s == ST_RDA_REQ) ||
               (s == ST_RDB_REQ) || (s == ST_WR_REQ);
    endfunction

    function automatic bm_op_e op_of(input srch_state_e s);
        case (s)
            ST_RST_REQ, ST_RST_WAIT:                         return BM_RESET;
            ST_RDA_REQ, ST_RDA_WAIT, ST_RDB_REQ, ST_RDB_WAIT: return BM_READ;
            default:                                         return BM_WRITE;
        endcase
    endfunction

endpackage

// File: rtl/idsearch_decide.sv
module idsearch_decide
    import idsearch_pkg::*;
#(
    parameter int IDXW = 7
) (
    input  logic            rd_first,
    input  logic            rd_second,
    input  logic [IDXW-1:0] pos_idx,
    input  logic [IDXW-1:0] last_disc,
    input  logic            prev_bit,
    output branch_t         branch
);

    always_comb begin
        branch.clash     = rd_first & rd_second;
        branch.fork_zero = ~rd_first & ~rd_second;
        if (rd_first != rd_second) begin
            branch.choice = rd_first;
        end else if (pos_idx == last_disc) begin
            branch.choice = 1'b1;
        end else if (pos_idx > last_disc) begin
            branch.choice = 1'b0;
        end else begin
            branch.choice = prev_bit;
        end
    end

endmodule

// File: rtl/idsearch_pattern.sv
module idsearch_pattern #(
    parameter int ID_BITS = 64,
    parameter int IDXW    = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [ID_BITS-1:0] load_val,
    input  logic               wr_en,
    input  logic [IDXW-1:0]    pos_idx,
    input  logic               wr_bit,
    output logic [ID_BITS-1:0] bits,
    output logic               pos_bit
);

    localparam int PW = (ID_BITS > 1) ? $clog2(ID_BITS) : 1;

    // positions count from 1, storage from 0
    logic [PW-1:0] slot;
    assign slot    = PW'(pos_idx - IDXW'(1));
    assign pos_bit = bits[slot];

    for (genvar g = 0; g < ID_BITS; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                bits[g] <= 1'b0;
            end else if (load) begin
                bits[g] <= load_val[g];
            end else if (wr_en && (slot == PW'(g))) begin
                bits[g] <= wr_bit;
            end
        end
    end

endmodule

// File: rtl/idsearch_engine.sv
module idsearch_engine
    import idsearch_pkg::*;
#(
    parameter int                  ID_BITS  = 64,
    parameter int                  CMD_BITS = 8,
    parameter logic [CMD_BITS-1:0] CMD_CODE = 8'hF0,
    parameter int                  IDXW     = $clog2(ID_BITS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [ID_BITS-1:0] prev_id,
    input  logic [IDXW-1:0]    prev_disc,
    output logic               busy,
    output logic               done,
    output logic [ID_BITS-1:0] found_id,
    output logic [IDXW-1:0]    found_disc,
    output logic [1:0]         result,
    output logic               bm_req,
    output logic [1:0]         bm_op,
    output logic               bm_wbit,
    input  logic               bm_done,
    input  logic               bm_rbit
);

    localparam int CMDW = (CMD_BITS > 1) ? $clog2(CMD_BITS) : 1;

    srch_state_e     state;
    logic [CMDW-1:0] cmd_cnt;
    logic [IDXW-1:0] pos_q;
    logic [IDXW-1:0] last_q;
    logic [IDXW-1:0] disc_q;
    logic            rd_first_q;
    logic            choice_q;
    res_code_e       code_q;

    branch_t         branch;
    logic            prev_bit;
    logic            pat_load;
    logic            pat_wr;

    assign pat_load = (state == ST_IDLE) && start;
    assign pat_wr   = (state == ST_RDB_WAIT) && bm_done && !branch.clash;

    idsearch_pattern #(
        .ID_BITS (ID_BITS),
        .IDXW    (IDXW)
    ) pattern_i (
        .clk      (clk),
        .rst      (rst),
        .load     (pat_load),
        .load_val (prev_id),
        .wr_en    (pat_wr),
        .pos_idx  (pos_q),
        .wr_bit   (branch.choice),
        .bits     (found_id),
        .pos_bit  (prev_bit)
    );

    idsearch_decide #(
        .IDXW (IDXW)
    ) decide_i (
        .rd_first  (rd_first_q),
        .rd_second (bm_rbit),
        .pos_idx   (pos_q),
        .last_disc (last_q),
        .prev_bit  (prev_bit),
        .branch    (branch)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cmd_cnt    <= '0;
            pos_q      <= '0;
            last_q     <= '0;
            disc_q     <= '0;
            rd_first_q <= 1'b0;
            choice_q   <= 1'b0;
            code_q     <= RES_MORE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        last_q <= prev_disc;
                        disc_q <= '0;
                        pos_q  <= IDXW'(1);
                        state  <= ST_RST_REQ;
                    end
                end
                ST_RST_REQ: state <= ST_RST_WAIT;
                ST_RST_WAIT: begin
                    if (bm_done) begin
                        if (bm_rbit) begin
                            cmd_cnt <= '0;
                            state   <= ST_CMD_REQ;
                        end else begin
                            code_q <= RES_NODEV;
                            state  <= ST_DONE;
                        end
                    end
                end
                ST_CMD_REQ: state <= ST_CMD_WAIT;
                ST_CMD_WAIT: begin
                    if (bm_done) begin
                        if (cmd_cnt == CMDW'(CMD_BITS - 1)) begin
                            pos_q <= IDXW'(1);
                            state <= ST_RDA_REQ;
                        end else begin
                            cmd_cnt <= cmd_cnt + CMDW'(1);
                            state   <= ST_CMD_REQ;
                        end
                    end
                end
                ST_RDA_REQ: state <= ST_RDA_WAIT;
                ST_RDA_WAIT: begin
                    if (bm_done) begin
                        rd_first_q <= bm_rbit;
                        state      <= ST_RDB_REQ;
                    end
                end
                ST_RDB_REQ: state <= ST_RDB_WAIT;
                ST_RDB_WAIT: begin
                    if (bm_done) begin
                        if (branch.clash) begin
                            code_q <= RES_FAIL;
                            state  <= ST_DONE;
                        end else begin
                            choice_q <= branch.choice;
                            if (branch.fork_zero && !branch.choice) begin
                                disc_q <= pos_q;
                            end
                            state <= ST_WR_REQ;
                        end
                    end
                end
                ST_WR_REQ: state <= ST_WR_WAIT;
                ST_WR_WAIT: begin
                    if (bm_done) begin
                        if (pos_q == IDXW'(ID_BITS)) begin
                            code_q <= (disc_q == '0) ? RES_LAST : RES_MORE;
                            state  <= ST_DONE;
                        end else begin
                            pos_q <= pos_q + IDXW'(1);
                            state <= ST_RDA_REQ;
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        bm_req = is_request(state);
        bm_op  = op_of(state);
        if ((state == ST_CMD_REQ) || (state == ST_CMD_WAIT)) begin
            bm_wbit = CMD_CODE[cmd_cnt];
        end else if ((state == ST_WR_REQ) || (state == ST_WR_WAIT)) begin
            bm_wbit = choice_q;
        end else begin
            bm_wbit = 1'b0;
        end
    end

    assign busy       = (state != ST_IDLE) && (state != ST_DONE);
    assign done       = (state == ST_DONE);
    assign found_disc = disc_q;
    assign result     = code_q;

endmodule

// File: rtl/idsearch_checker.sv
module idsearch_checker #(
    parameter int IDXW = 7
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            bm_req,
    input logic            bm_done,
    input logic [IDXW-1:0] found_disc,
    input logic [1:0]      result
);

    logic pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (bm_req) begin
            pending <= 1'b1;
        end else if (bm_done) begin
            pending <= 1'b0;
        end
    end

    p_one_outstanding_r10: assert property (@(posedge clk) disable iff (rst)
        pending |-> !bm_req);

    p_idle_silent_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bm_req);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_not_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_start_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done) |=> busy);

    p_disc_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(found_disc) && $stable(result)));

endmodule

bind idsearch_engine idsearch_checker #(
    .IDXW (IDXW)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .bm_req     (bm_req),
    .bm_done    (bm_done),
    .found_disc (found_disc),
    .result     (result)
);

// File: tb/idsearch_engine_tb_top.sv
`timescale 1ns/1ps
module idsearch_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [63:0] prev_id;
    logic [6:0]  prev_disc;
    logic        busy, done;
    logic [63:0] found_id;
    logic [6:0]  found_disc;
    logic [1:0]  result;
    logic        bm_req;
    logic [1:0]  bm_op;
    logic        bm_wbit;
    logic        bm_done;
    logic        bm_rbit;

    int checks = 0;
    int fails  = 0;

    // bus model state
    logic [63:0] devs [8];
    int          ndev;
    bit          active [8];
    bit          broken;
    int          slot;
    int          resets;
    logic [7:0]  cmd_seen;

    always #2 clk = ~clk;

    idsearch_engine dut_i (
        .clk(clk), .rst(rst), .start(start), .prev_id(prev_id), .prev_disc(prev_disc),
        .busy(busy), .done(done), .found_id(found_id), .found_disc(found_disc),
        .result(result), .bm_req(bm_req), .bm_op(bm_op), .bm_wbit(bm_wbit),
        .bm_done(bm_done), .bm_rbit(bm_rbit)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // slave population answering the bit-level master
    initial begin : responder
        bm_done = 1'b0;
        bm_rbit = 1'b0;
        forever begin
            @(negedge clk);
            while (bm_req) begin
                logic [1:0] op;
                logic       w;
                logic       r;
                int         lat;
                op  = bm_op;
                w   = bm_wbit;
                lat = 1 + int'($urandom_range(2, 0));
                repeat (lat) @(negedge clk);
                r = 1'b0;
                if (op == 2'd0) begin
                    resets++;
                    slot = 0;
                    for (int k = 0; k < 8; k++) active[k] = (k < ndev);
                    r = (ndev > 0);
                end else if (op == 2'd1) begin
                    if (slot < 8) begin
                        cmd_seen[slot] = w;
                    end else begin
                        for (int k = 0; k < 8; k++)
                            if (active[k] && devs[k][(slot - 8) / 3] != w) active[k] = 0;
                    end
                    slot++;
                end else begin
                    r = 1'b1;
                    for (int k = 0; k < 8; k++)
                        if (active[k])
                            r = r & (((slot - 8) % 3 == 0) ? devs[k][(slot - 8) / 3]
                                                            : ~devs[k][(slot - 8) / 3]);
                    if (broken) r = 1'b1;
                    slot++;
                end
                bm_rbit = r;
                bm_done = 1'b1;
                @(negedge clk);
                bm_done = 1'b0;
            end
        end
    end

    // reference search rule over the modelled population
    function automatic void ref_pass(input logic [63:0] p, input int last,
                                     output logic [63:0] id, output int disc, output logic [1:0] code);
        bit act [8];
        id = p; disc = 0; code = 2'd0;
        if (ndev == 0) begin code = 2'd2; return; end
        for (int k = 0; k < 8; k++) act[k] = (k < ndev);
        for (int i = 1; i <= 64; i++) begin
            logic a, b, ch;
            a = 1'b1; b = 1'b1;
            for (int k = 0; k < 8; k++)
                if (act[k]) begin
                    a = a & devs[k][i-1];
                    b = b & ~devs[k][i-1];
                end
            if (a && b) begin code = 2'd3; return; end
            if (a != b)        ch = a;
            else if (i == last) ch = 1'b1;
            else if (i > last)  ch = 1'b0;
            else                ch = p[i-1];
            if (!a && !b && !ch) disc = i;
            id[i-1] = ch;
            for (int k = 0; k < 8; k++)
                if (act[k] && devs[k][i-1] != ch) act[k] = 0;
        end
        code = (disc == 0) ? 2'd1 : 2'd0;
    endfunction

    task automatic run_pass(input logic [63:0] p_id, input logic [6:0] p_disc, input bit mid,
                            output logic [63:0] o_id, output logic [6:0] o_disc, output logic [1:0] o_code);
        int t;
        @(negedge clk);
        prev_id = p_id; prev_disc = p_disc; resets = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8 busy after start", 64'(busy), 64'd1);
        if (mid) begin
            // R9: start and new inputs during a pass
            repeat (20) @(negedge clk);
            prev_id = {$urandom, $urandom}; prev_disc = 7'd5; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && t < 5000) begin @(negedge clk); t++; end
        chk(done == 1'b1, "R8 done reached", 64'(done), 64'd1);
        o_id = found_id; o_disc = found_disc; o_code = result;
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R8 done single cycle", 64'(done), 64'd0);
        chk(resets == 1, "R2 one reset per pass", 64'(resets), 64'd1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog expired: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [63:0] id, eid, base, keep;
        logic [6:0]  disc;
        logic [1:0]  code, ecode;
        int          edisc;
        void'($urandom(32'd4242));
        rst = 1'b1; start = 1'b0; prev_id = '0; prev_disc = '0;
        ndev = 0; broken = 0; slot = 0; resets = 0; cmd_seen = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !bm_req, "R1 reset state", {61'd0, busy, done, bm_req}, 64'd0);

        // R2: empty bus
        ndev = 0;
        run_pass(64'd0, 7'd0, 0, id, disc, code);
        chk(code == 2'd2, "R2 no presence code", 64'(code), 64'd2);
        chk(slot == 0, "R2 no slot after missing presence", 64'(slot), 64'd0);

        // R4: bus stuck high gives clash on first position
        ndev = 1; devs[0] = 64'h0123_4567_89AB_CDEF; broken = 1;
        run_pass(64'd0, 7'd0, 0, id, disc, code);
        chk(code == 2'd3, "R4 clash code", 64'(code), 64'd3);
        chk(slot == 10, "R4 no write after clash", 64'(slot), 64'd10);
        chk(cmd_seen == 8'hF0, "R3 command byte", 64'(cmd_seen), 64'hF0);
        broken = 0;

        // R6/R7 directed: all-zero and all-one devices fork at position 1
        ndev = 2; devs[0] = 64'd0; devs[1] = ~64'd0;
        run_pass(64'd0, 7'd0, 0, id, disc, code);
        chk(id == 64'd0, "R6 pass1 id", id, 64'd0);
        chk(disc == 7'd1 && code == 2'd0, "R7 pass1 disc", {55'd0, code, disc}, {55'd0, 2'd0, 7'd1});
        run_pass(id, disc, 0, id, disc, code);
        chk(id == ~64'd0, "R6 pass2 id", id, ~64'd0);
        chk(disc == 7'd0 && code == 2'd1, "R7 pass2 last", {55'd0, code, disc}, {55'd0, 2'd1, 7'd0});

        // random populations, full enumeration
        for (int s = 0; s < 6; s++) begin
            int   found;
            bit   seen [8];
            logic [63:0] pid;
            logic [6:0]  pdisc;
            ndev = 2 + int'($urandom_range(4, 0));
            base = {$urandom, $urandom};
            keep = {$urandom, $urandom};
            for (int k = 0; k < 8; k++) begin
                seen[k] = 0;
                devs[k] = (base & keep) | ({$urandom, $urandom} & ~keep);
                if (s % 2 == 0) devs[k][2:0] = 3'(k);
                else            devs[k][63:61] = 3'(k);
            end
            found = 0; pid = '0; pdisc = '0;
            for (int pass = 0; pass <= ndev; pass++) begin
                ref_pass(pid, int'(pdisc), eid, edisc, ecode);
                run_pass(pid, pdisc, (pass == 1), id, disc, code);
                chk(id == eid, "R5 R6 R9 identifier", id, eid);
                chk(disc == 7'(edisc), "R7 discrepancy", 64'(disc), 64'(edisc));
                chk(code == ecode, "R7 result code", 64'(code), 64'(ecode));
                for (int k = 0; k < ndev; k++)
                    if (devs[k] == id && !seen[k]) begin seen[k] = 1; found++; end
                pid = id; pdisc = disc;
                if (code != 2'd0) break;
            end
            chk(cmd_seen == 8'hF0, "R3 command byte", 64'(cmd_seen), 64'hF0);
            chk(found == ndev, "R7 R8 all devices found", 64'(found), 64'(ndev));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule